// File: doc/BRIEF.md
# Bit-Vector Overlap Matcher

The matcher compares one wide binary key vector against a table of stored binary class vectors in a single pass over the table. For each class it counts the bits set in both the key and the stored vector. It reports the index of every class whose count reaches a caller-supplied threshold. It also keeps a running maximum of the counts and reports it on completion.

A run begins when `start` is seen while the block is idle. The key and the threshold are captured at that edge and the running maximum is cleared. The table is then read one slice per cycle, class by class, in ascending class order. The slice counts of a class are summed before any comparison. Qualifying indices leave on `hit_idx`, each with a one-cycle `hit_valid` pulse. A one-cycle `done` pulse then presents the final maximum and the threshold that was used.

The table is filled beforehand, one slice at a time, through a write port. The table is a plain synchronous memory that maps onto block RAM. The number of slices per vector (`VEC_W/SLICE_W`) must be a power of two.

Top module: `ovlm_matcher`

## Requirements
- R1: `start` is taken only when the block is idle. It captures `key_vec` and `thr` at that edge. A `start` pulse, a new key or a new threshold applied while a run is in progress has no effect on that run's outputs.
- R2: The overlap of class c is the number of bit positions i in 0..VEC_W-1 where both `key_vec[i]` and bit i of class c are 1. It ranges from 0 to VEC_W.
- R3: Class c is reported on `hit_idx` when its overlap is greater than or equal to the captured threshold. It is not reported when the overlap is lower. Reported indices come in ascending order, each with `hit_valid` high for exactly one cycle.
- R4: With S = VEC_W/SLICE_W and the accepting edge counted as edge 0, the report for class c appears after edge (c+1)*S+2. `hit_valid` is low on every other cycle.
- R5: The running maximum is cleared at the accepting edge. It is replaced only by a strictly larger overlap. `max_out` gives the largest overlap of the run.
- R6: After edge N_CLASS*S+2, `done` is high for one cycle. On that cycle `max_out` holds the run's maximum and `thr_out` holds the captured threshold. Both keep their values until the next completion.
- R7: When `ld_en` is high, `ld_data` is written to slice `ld_slice` of class `ld_cls`. Slice s covers vector bits s*SLICE_W to s*SLICE_W+SLICE_W-1. Runs started after the write use the new contents.
- R8: After synchronous reset, `hit_valid`, `done`, `hit_idx`, `max_out` and `thr_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Table write enable |
| ld_cls | input | $clog2(N_CLASS) | Class written |
| ld_slice | input | SW | Slice of the class written |
| ld_data | input | SLICE_W | Slice contents |
| start | input | 1 | Begin a run (taken when idle) |
| key_vec | input | VEC_W | Key vector |
| thr | input | CNT_W | Reporting threshold |
| hit_valid | output | 1 | One-cycle pulse for a reported class |
| hit_idx | output | $clog2(N_CLASS) | Reported class index |
| done | output | 1 | One-cycle pulse on completion |
| max_out | output | CNT_W | Largest overlap of the last run |
| thr_out | output | CNT_W | Threshold used by the last run |

## Verification
Every result has a fixed cycle after the accepting edge. The report for class c is due after edge (c+1)*S+2, and `done` is due after edge N_CLASS*S+2. The bench counts edges from the accepting edge and samples on each falling edge. On every cycle of a run it compares `hit_valid` with the expected pulse pattern, so an early, late or extra report is caught on the cycle it occurs. The expected index, maximum and threshold are checked on the cycles where they are due.

// File: rtl/ovlm_pkg.sv
package ovlm_pkg;
  localparam int DEF_VEC_W   = 256;
  localparam int DEF_N_CLASS = 16;
  localparam int DEF_SLICE_W = 64;
  localparam int DEF_CNT_W   = 13;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SCAN  = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ovlm_store.sv
module ovlm_store #(
  parameter int W  = 64,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ovlm_accum.sv
module ovlm_accum #(
  parameter int VEC_W   = 256,
  parameter int SLICE_W = 64,
  parameter int CNT_W   = 13,
  parameter int CW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [CW-1:0]      in_cls,
  input  logic [SLICE_W-1:0] row,
  input  logic [SLICE_W-1:0] key,
  output logic               ovl_valid,
  output logic [CNT_W-1:0]   ovl,
  output logic [CW-1:0]      ovl_cls
);
  localparam int PW = $clog2(SLICE_W + 1);

  logic [SLICE_W-1:0] both;
  logic [PW-1:0]      pop;
  logic [CNT_W-1:0]   acc;
  logic [CNT_W-1:0]   sum;

  assign both = row & key;

  always_comb begin
    pop = '0;
    for (int i = 0; i < SLICE_W; i++) pop = pop + PW'(both[i]);
  end

  assign sum = acc + CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      ovl_valid <= 1'b0;
      ovl       <= '0;
      ovl_cls   <= '0;
    end else begin
      ovl_valid <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          acc       <= '0;
          ovl       <= sum;
          ovl_cls   <= in_cls;
          ovl_valid <= 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end

  p_ovl_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ovl_valid |-> (ovl <= CNT_W'(VEC_W)));
endmodule

// File: rtl/ovlm_judge.sv
module ovlm_judge #(
  parameter int N_CLASS = 16,
  parameter int CNT_W   = 13,
  parameter int CW      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  input  logic             ovl_valid,
  input  logic [CNT_W-1:0] ovl,
  input  logic [CW-1:0]    ovl_cls,
  output logic             hit_valid,
  output logic [CW-1:0]    hit_idx,
  output logic             done,
  output logic [CNT_W-1:0] max_out,
  output logic [CNT_W-1:0] thr_out
);
  localparam logic [CW-1:0] LAST_CLS = CW'(N_CLASS - 1);

  logic [CNT_W-1:0] max_q;
  logic [CNT_W-1:0] max_nxt;

  assign max_nxt = (ovl > max_q) ? ovl : max_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q     <= '0;
      hit_valid <= 1'b0;
      hit_idx   <= '0;
      done      <= 1'b0;
      max_out   <= '0;
      thr_out   <= '0;
    end else begin
      hit_valid <= 1'b0;
      done      <= 1'b0;
      if (clr) begin
        max_q <= '0;
      end else if (ovl_valid) begin
        max_q <= max_nxt;
        if (ovl >= thr) begin
          hit_valid <= 1'b1;
          hit_idx   <= ovl_cls;
        end
        if (ovl_cls == LAST_CLS) begin
          done    <= 1'b1;
          max_out <= max_nxt;
          thr_out <= thr;
        end
      end
    end
  end

  p_max_grows_r5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (max_q >= $past(max_q)));
  p_max_covers_hit_r5: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> (max_q >= $past(ovl)));
  p_hit_from_ovl_r3: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(ovl_valid));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ovlm_matcher.sv
module ovlm_matcher
  import ovlm_pkg::*;
#(
  parameter int VEC_W   = DEF_VEC_W,
  parameter int N_CLASS = DEF_N_CLASS,
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int CNT_W   = DEF_CNT_W,
  localparam int SLICES = VEC_W / SLICE_W,
  localparam int CW     = (N_CLASS > 1) ? $clog2(N_CLASS) : 1,
  localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [CW-1:0]      ld_cls,
  input  logic [SW-1:0]      ld_slice,
  input  logic [SLICE_W-1:0] ld_data,
  input  logic               start,
  input  logic [VEC_W-1:0]   key_vec,
  input  logic [CNT_W-1:0]   thr,
  output logic               hit_valid,
  output logic [CW-1:0]      hit_idx,
  output logic               done,
  output logic [CNT_W-1:0]   max_out,
  output logic [CNT_W-1:0]   thr_out
);
  localparam int AW = CW + SW;
  localparam logic [CW-1:0] LAST_CLS = CW'(N_CLASS - 1);
  localparam logic [SW-1:0] LAST_SL  = SW'(SLICES - 1);

  seq_state_t st;
  logic             take;
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] thr_q;
  logic [CW-1:0]    cls;
  logic [SW-1:0]    slc;
  logic             rd_valid;
  logic             rd_last;
  logic [CW-1:0]    rd_cls;
  logic [SW-1:0]    rd_slc;
  logic [SLICE_W-1:0] rd_row;
  logic [SLICE_W-1:0] key_sl [SLICES];
  logic             ovl_valid;
  logic [CNT_W-1:0] ovl;
  logic [CW-1:0]    ovl_cls;

  assign take = start && (st == SQ_IDLE);

  for (genvar g = 0; g < SLICES; g++) begin : g_key
    assign key_sl[g] = vec_q[g*SLICE_W +: SLICE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      vec_q    <= '0;
      thr_q    <= '0;
      cls      <= '0;
      slc      <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_cls   <= '0;
      rd_slc   <= '0;
    end else begin
      rd_valid <= (st == SQ_SCAN);
      rd_last  <= (slc == LAST_SL);
      rd_cls   <= cls;
      rd_slc   <= slc;
      case (st)
        SQ_IDLE: if (take) begin
          vec_q <= key_vec;
          thr_q <= thr;
          cls   <= '0;
          slc   <= '0;
          st    <= SQ_SCAN;
        end
        SQ_SCAN: begin
          if (slc == LAST_SL) begin
            slc <= '0;
            if (cls == LAST_CLS) st <= SQ_DRAIN;
            else cls <= cls + 1'b1;
          end else begin
            slc <= slc + 1'b1;
          end
        end
        SQ_DRAIN: if (done) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  ovlm_store #(.W(SLICE_W), .AW(AW)) u_store (
    .clk   (clk),
    .we    (ld_en),
    .waddr ({ld_cls, ld_slice}),
    .wdata (ld_data),
    .raddr ({cls, slc}),
    .rdata (rd_row)
  );

  ovlm_accum #(.VEC_W(VEC_W), .SLICE_W(SLICE_W), .CNT_W(CNT_W), .CW(CW)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_valid),
    .in_last   (rd_last),
    .in_cls    (rd_cls),
    .row       (rd_row),
    .key       (key_sl[rd_slc]),
    .ovl_valid (ovl_valid),
    .ovl       (ovl),
    .ovl_cls   (ovl_cls)
  );

  ovlm_judge #(.N_CLASS(N_CLASS), .CNT_W(CNT_W), .CW(CW)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .clr       (take),
    .thr       (thr_q),
    .ovl_valid (ovl_valid),
    .ovl       (ovl),
    .ovl_cls   (ovl_cls),
    .hit_valid (hit_valid),
    .hit_idx   (hit_idx),
    .done      (done),
    .max_out   (max_out),
    .thr_out   (thr_out)
  );

  p_no_read_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE) |=> !rd_valid);
  p_key_held_r1: assert property (@(posedge clk) disable iff (rst)
    (st != SQ_IDLE) |=> ($stable(vec_q) && $stable(thr_q)));
  p_hit_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> (st != SQ_IDLE));
endmodule

// File: tb/ovlm_matcher_tb.sv
`timescale 1ns/1ps
module ovlm_matcher_tb;
  localparam int VEC_W   = 256;
  localparam int N_CLASS = 16;
  localparam int SLICE_W = 64;
  localparam int CNT_W   = 13;
  localparam int S       = VEC_W / SLICE_W;
  localparam int CW      = $clog2(N_CLASS);
  localparam int SW      = $clog2(S);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [CW-1:0] ld_cls = '0;
  logic [SW-1:0] ld_slice = '0;
  logic [SLICE_W-1:0] ld_data = '0;
  logic start = 1'b0;
  logic [VEC_W-1:0] key_vec = '0;
  logic [CNT_W-1:0] thr = '0;
  logic hit_valid, done;
  logic [CW-1:0] hit_idx;
  logic [CNT_W-1:0] max_out, thr_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [VEC_W-1:0] tbl [N_CLASS];

  always #2 clk = ~clk;

  ovlm_matcher #(.VEC_W(VEC_W), .N_CLASS(N_CLASS), .SLICE_W(SLICE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_cls(ld_cls), .ld_slice(ld_slice),
    .ld_data(ld_data), .start(start), .key_vec(key_vec), .thr(thr),
    .hit_valid(hit_valid), .hit_idx(hit_idx), .done(done),
    .max_out(max_out), .thr_out(thr_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int overlap(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    int n = 0;
    for (int i = 0; i < VEC_W; i++) n += int'(a[i] & b[i]);
    return n;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic load_class(input int c);
    for (int s = 0; s < S; s++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_cls = CW'(c); ld_slice = SW'(s);
      ld_data = tbl[c][s*SLICE_W +: SLICE_W];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // One run: start, then check every cycle at the falling edge after edge n.
  task automatic run(input logic [VEC_W-1:0] v, input int th, input bit inject, input string tag);
    int ov [N_CLASS];
    int mx = 0;
    for (int c = 0; c < N_CLASS; c++) begin
      ov[c] = overlap(v, tbl[c]);
      if (ov[c] > mx) mx = ov[c];
    end
    @(negedge clk);
    key_vec = v; thr = CNT_W'(th); start = 1'b1;
    @(negedge clk);   // edge 0 has passed
    start = 1'b0;
    for (int n = 1; n <= N_CLASS*S + 3; n++) begin
      bit exp_hit = 1'b0;
      int ec = 0;
      @(negedge clk);
      if (n >= S + 2 && ((n - 2) % S) == 0) begin
        ec = (n - 2) / S - 1;
        if (ec < N_CLASS) exp_hit = (ov[ec] >= th);
      end
      chk(hit_valid == exp_hit, {tag, " R3 R4 hit_valid"}, int'(hit_valid), int'(exp_hit));
      if (exp_hit) chk(int'(hit_idx) == ec, {tag, " R3 hit_idx"}, int'(hit_idx), ec);
      chk(done == (n == N_CLASS*S + 2), {tag, " R6 done"}, int'(done), int'(n == N_CLASS*S + 2));
      if (n == N_CLASS*S + 2) begin
        chk(int'(max_out) == mx, {tag, " R5 max_out"}, int'(max_out), mx);
        chk(int'(thr_out) == th, {tag, " R6 thr_out"}, int'(thr_out), th);
      end
      if (inject && n == 3) begin   // R1: disturbances during a run
        start = 1'b1; key_vec = ~v; thr = '0;
      end
      if (inject && n == 4) begin
        start = 1'b0; key_vec = v; thr = CNT_W'(th);
      end
    end
    @(negedge clk);
    chk(int'(max_out) == mx, {tag, " R6 max_out held"}, int'(max_out), mx);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] v;
    int th;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(hit_valid == 1'b0, "R8 hit_valid", int'(hit_valid), 0);
    chk(done == 1'b0, "R8 done", int'(done), 0);
    chk(hit_idx == '0, "R8 hit_idx", int'(hit_idx), 0);
    chk(max_out == '0, "R8 max_out", int'(max_out), 0);
    chk(thr_out == '0, "R8 thr_out", int'(thr_out), 0);

    tbl[0] = '0;
    tbl[N_CLASS-1] = '1;
    for (int c = 1; c < N_CLASS - 1; c++) tbl[c] = rnd_vec();
    tbl[2] = tbl[1];   // tie
    for (int c = 0; c < N_CLASS; c++) load_class(c);

    run('1, 0, 1'b0, "R2 all-ones");
    run('0, 0, 1'b0, "R5 zero key clears max");
    run('0, 1, 1'b0, "R3 zero key none");
    v = rnd_vec();
    run(v, overlap(v, tbl[3]), 1'b0, "R3 thr equals class3");
    v = rnd_vec();
    th = 0;
    for (int c = 0; c < N_CLASS; c++) if (overlap(v, tbl[c]) > th) th = overlap(v, tbl[c]);
    run(v, th + 1, 1'b0, "R3 above max");
    run(v, th, 1'b0, "R3 at max");
    run(rnd_vec(), VEC_W / 4, 1'b1, "R1 start ignored");
    for (int k = 0; k < 8; k++) run(rnd_vec(), int'($urandom_range(VEC_W / 2)), 1'b0, "R2 sweep");

    tbl[5] = '1;       // R7: rewrite one class
    load_class(5);
    run('1, VEC_W, 1'b0, "R7 rewritten class");
    tbl[0] = rnd_vec();
    load_class(0);
    run(rnd_vec(), VEC_W / 4, 1'b0, "R7 rewritten class0");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule